// File: doc/BRIEF.md
# Maskable Output Macrocell Bank

This block holds sixteen single-bit state registers arranged as two groups of eight, sitting between a programmable logic array and a set of port pins. Each register can be loaded from two sides. The logic array presents a next-state value and a per-cell load enable. A microcontroller can also store a byte into a whole group through an 8-bit register interface.

Each group has a mask byte that stops bus stores from reaching chosen cells. This lets logic-owned state, such as the bits of a state machine, share a group with software-owned bits without being disturbed by a byte-wide store. For example, a mask of 0Fh shields cells 0 to 3 of a group and leaves cells 4 to 7 open to software.

Every cell always feeds its value back to the logic array. A cell configured as a pin output also drives its pin. The pin's driver is switched on by a product-term enable ORed with a per-pin direction bit. A pin with no enable equation is driven at all times.

Top module: `mcell_bank`

## Requirements
- R1: After reset, every cell, mask bit and direction bit is 0, and each of the six register addresses reads 00h.
- R2: A bus store to cell address g (address 0 holds cells 0-7, address 1 holds cells 8-15, bus bit b maps to cell g*8+b) loads each cell whose mask bit is 0 with the stored bit on the next clock.
- R3: A cell whose mask bit is 1 ignores bus stores: it holds its value, or takes its logic next-state when its logic load enable is high.
- R4: With a group mask of 0Fh, a store of FFh over a group holding A5h leaves F5h: cells 0-3 are protected and cells 4-7 are written.
- R5: When a cell is not receiving an unmasked bus store, a high logic load enable loads the logic next-state bit on the next clock; with the enable low the cell holds.
- R6: When an unmasked bus store and a logic load hit the same cell in the same cycle, the bus data wins.
- R7: Register map: address 2 and 3 hold the masks of groups 0 and 1, and address 4 and 5 hold the direction bytes of groups 0 and 1. All six addresses are writable and read back through the read data port, which is combinational on the address. Addresses 6 and 7 read 00h, and stores to them change nothing.
- R8: For a pin-output cell that has an enable equation, the pin enable is the product-term enable ORed with the pin's direction bit.
- R9: A pin-output cell without an enable equation has its pin enabled at all times, including during reset.
- R10: A cell configured as an internal node drives neither its pin enable nor its pin data (both 0), which leaves the pin free.
- R11: The feedback output of every cell equals the cell value, and a pin-output cell's pin data equals the cell value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we_i | input | 1 | Bus store strobe, one cycle per store |
| bus_addr_i | input | 3 | Register address for stores and reads |
| bus_wdata_i | input | 8 | Bus store data |
| bus_rdata_o | output | 8 | Read data for the current address |
| lg_en_i | input | 16 | Per-cell logic load enable |
| lg_next_i | input | 16 | Per-cell logic next-state value |
| pt_oe_i | input | 16 | Per-pin product-term output enable |
| cfg_pin_i | input | 16 | 1: cell drives its pin; 0: internal node only |
| cfg_oe_eq_i | input | 16 | 1: pin has an enable equation; 0: always driven |
| fb_o | output | 16 | Cell values fed back to the logic array |
| pin_o | output | 16 | Pin data |
| pin_oe_o | output | 16 | Pin driver enable |

## Verification
On every cycle, the bound assertions check each of the sixteen cells. A masked cell with no logic enable keeps its value across a store. An unmasked cell takes the stored bit. A cell outside a store takes its logic next-state when enabled. The pin enable follows the product-term, direction and configuration rules, and unmapped addresses read zero. Some behaviour only the bench's scenarios show: the reset contents seen through the register interface, the 0Fh split example, and the bus-over-logic priority on a shared cycle with a specific outcome. The bench also shows that stores to unmapped addresses leave all six registers untouched, and a long pseudo-random run is checked against a behavioural model.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

  // Kind of register selected by the bus address.
  typedef enum logic [1:0] {
    K_CELL = 2'd0,
    K_MASK = 2'd1,
    K_DIR  = 2'd2,
    K_NONE = 2'd3
  } reg_kind_e;

  // Number of register slots per group kind (cells, masks, directions).
  localparam int KINDS = 3;

endpackage

// File: rtl/mcb_rst_sync.sv
module mcb_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sn_o
);

  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sn_o = s2_q;

endmodule

// File: rtl/mcb_decode.sv
module mcb_decode import mcb_pkg::*; #(
  parameter int GROUPS = 2,
  parameter int ADDR_W = 3,
  parameter int GIW    = 1
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [GROUPS-1:0] cell_we_o,
  output logic [GROUPS-1:0] mask_we_o,
  output logic [GROUPS-1:0] dir_we_o,
  output reg_kind_e         kind_o,
  output logic [GIW-1:0]    grp_o
);

  int a;

  always_comb begin
    a      = int'(addr_i);
    kind_o = K_NONE;
    grp_o  = '0;
    if (a < GROUPS) begin
      kind_o = K_CELL;
      grp_o  = GIW'(a);
    end else if (a < 2 * GROUPS) begin
      kind_o = K_MASK;
      grp_o  = GIW'(a - GROUPS);
    end else if (a < KINDS * GROUPS) begin
      kind_o = K_DIR;
      grp_o  = GIW'(a - 2 * GROUPS);
    end
  end

  always_comb begin
    cell_we_o = '0;
    mask_we_o = '0;
    dir_we_o  = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (we_i && int'(grp_o) == g) begin
        cell_we_o[g] = (kind_o == K_CELL);
        mask_we_o[g] = (kind_o == K_MASK);
        dir_we_o[g]  = (kind_o == K_DIR);
      end
    end
  end

endmodule

// File: rtl/mcb_ctrl_regs.sv
module mcb_ctrl_regs #(
  parameter int GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_we_i,
  input  logic          dir_we_i,
  input  logic [GW-1:0] wdata_i,
  output logic [GW-1:0] mask_o,
  output logic [GW-1:0] dir_o
);

  logic [GW-1:0] mask_q, mask_d;
  logic [GW-1:0] dir_q, dir_d;
  logic          mask_en, dir_en;

  always_comb begin
    mask_en = mask_we_i;
    dir_en  = dir_we_i;
    mask_d  = wdata_i;
    dir_d   = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      dir_q  <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (dir_en)  dir_q  <= dir_d;
    end
  end

  assign mask_o = mask_q;
  assign dir_o  = dir_q;

endmodule

// File: rtl/mcb_cell_group.sv
module mcb_cell_group #(
  parameter int GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [GW-1:0] wdata_i,
  input  logic [GW-1:0] mask_i,
  input  logic [GW-1:0] lg_en_i,
  input  logic [GW-1:0] lg_next_i,
  output logic [GW-1:0] q_o
);

  logic [GW-1:0] cell_q, cell_d, cell_en, bus_hit;

  // Bus store takes priority over logic load on an unmasked cell.
  always_comb begin
    for (int b = 0; b < GW; b++) begin
      bus_hit[b] = bus_we_i && !mask_i[b];
      cell_en[b] = bus_hit[b] || lg_en_i[b];
      cell_d[b]  = bus_hit[b] ? wdata_i[b] : lg_next_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cell_q <= '0;
    end else begin
      for (int b = 0; b < GW; b++) begin
        if (cell_en[b]) cell_q[b] <= cell_d[b];
      end
    end
  end

  assign q_o = cell_q;

endmodule

// File: rtl/mcb_pin_ctl.sv
module mcb_pin_ctl #(
  parameter int N = 16
) (
  input  logic [N-1:0] cell_i,
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] pt_oe_i,
  input  logic [N-1:0] cfg_pin_i,
  input  logic [N-1:0] cfg_oe_eq_i,
  output logic [N-1:0] pin_o,
  output logic [N-1:0] pin_oe_o
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic drv_term;
    assign drv_term    = cfg_oe_eq_i[i] ? (pt_oe_i[i] | dir_i[i]) : 1'b1;
    assign pin_oe_o[i] = cfg_pin_i[i] & drv_term;
    assign pin_o[i]    = cfg_pin_i[i] & cell_i[i];
  end

endmodule

// File: rtl/mcell_bank.sv
module mcell_bank import mcb_pkg::*; #(
  parameter  int GROUPS = 2,
  parameter  int GW     = 8,
  localparam int N      = GROUPS * GW,
  localparam int ADDR_W = $clog2(KINDS * GROUPS + 1),
  localparam int GIW    = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [GW-1:0]     bus_wdata_i,
  output logic [GW-1:0]     bus_rdata_o,
  input  logic [N-1:0]      lg_en_i,
  input  logic [N-1:0]      lg_next_i,
  input  logic [N-1:0]      pt_oe_i,
  input  logic [N-1:0]      cfg_pin_i,
  input  logic [N-1:0]      cfg_oe_eq_i,
  output logic [N-1:0]      fb_o,
  output logic [N-1:0]      pin_o,
  output logic [N-1:0]      pin_oe_o
);

  logic              rst_sn;
  logic [GROUPS-1:0] cell_we, mask_we, dir_we;
  reg_kind_e         rd_kind;
  logic [GIW-1:0]    rd_grp;
  logic [N-1:0]      cell_q, mask_q, dir_q;

  mcb_rst_sync u_rst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rst_sn_o (rst_sn)
  );

  mcb_decode #(.GROUPS(GROUPS), .ADDR_W(ADDR_W), .GIW(GIW)) u_dec (
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .cell_we_o (cell_we),
    .mask_we_o (mask_we),
    .dir_we_o  (dir_we),
    .kind_o    (rd_kind),
    .grp_o     (rd_grp)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    mcb_ctrl_regs #(.GW(GW)) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_sn),
      .mask_we_i (mask_we[g]),
      .dir_we_i  (dir_we[g]),
      .wdata_i   (bus_wdata_i),
      .mask_o    (mask_q[g*GW +: GW]),
      .dir_o     (dir_q[g*GW +: GW])
    );

    mcb_cell_group #(.GW(GW)) u_cells (
      .clk_i     (clk_i),
      .rst_ni    (rst_sn),
      .bus_we_i  (cell_we[g]),
      .wdata_i   (bus_wdata_i),
      .mask_i    (mask_q[g*GW +: GW]),
      .lg_en_i   (lg_en_i[g*GW +: GW]),
      .lg_next_i (lg_next_i[g*GW +: GW]),
      .q_o       (cell_q[g*GW +: GW])
    );
  end

  mcb_pin_ctl #(.N(N)) u_pins (
    .cell_i      (cell_q),
    .dir_i       (dir_q),
    .pt_oe_i     (pt_oe_i),
    .cfg_pin_i   (cfg_pin_i),
    .cfg_oe_eq_i (cfg_oe_eq_i),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe_o)
  );

  assign fb_o = cell_q;

  // Read path: combinational on the address.
  always_comb begin
    bus_rdata_o = '0;
    case (rd_kind)
      K_CELL:  bus_rdata_o = cell_q[int'(rd_grp)*GW +: GW];
      K_MASK:  bus_rdata_o = mask_q[int'(rd_grp)*GW +: GW];
      K_DIR:   bus_rdata_o = dir_q[int'(rd_grp)*GW +: GW];
      default: bus_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/mcell_bank_chk.sv
module mcell_bank_chk #(
  parameter int GROUPS = 2,
  parameter int GW     = 8,
  parameter int N      = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_sn,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [GW-1:0]     bus_wdata_i,
  input logic [GW-1:0]     bus_rdata_o,
  input logic [N-1:0]      lg_en_i,
  input logic [N-1:0]      lg_next_i,
  input logic [N-1:0]      pt_oe_i,
  input logic [N-1:0]      cfg_pin_i,
  input logic [N-1:0]      cfg_oe_eq_i,
  input logic [N-1:0]      pin_o,
  input logic [N-1:0]      pin_oe_o,
  input logic [N-1:0]      cell_q,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      dir_q
);

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam int G = i / GW;
    localparam int B = i % GW;
    logic hit;
    assign hit = bus_we_i && (int'(bus_addr_i) == G);

    a_r2_unmasked_load : assert property (@(posedge clk_i) disable iff (!rst_sn)
      (hit && !mask_q[i]) |=> (cell_q[i] == $past(bus_wdata_i[B])));

    a_r3_masked_hold : assert property (@(posedge clk_i) disable iff (!rst_sn)
      (hit && mask_q[i] && !lg_en_i[i]) |=> $stable(cell_q[i]));

    a_r5_logic_load : assert property (@(posedge clk_i) disable iff (!rst_sn)
      (!(hit && !mask_q[i]) && lg_en_i[i]) |=> (cell_q[i] == $past(lg_next_i[i])));

    a_r8_oe_term : assert property (@(posedge clk_i) disable iff (!rst_sn)
      (cfg_pin_i[i] && cfg_oe_eq_i[i]) |-> (pin_oe_o[i] == (pt_oe_i[i] | dir_q[i])));

    a_r9_no_eq_driven : assert property (@(posedge clk_i) disable iff (!rst_sn)
      (cfg_pin_i[i] && !cfg_oe_eq_i[i]) |-> pin_oe_o[i]);

    a_r10_node_quiet : assert property (@(posedge clk_i) disable iff (!rst_sn)
      !cfg_pin_i[i] |-> (!pin_oe_o[i] && !pin_o[i]));
  end

  a_r7_unmapped_zero : assert property (@(posedge clk_i) disable iff (!rst_sn)
    (int'(bus_addr_i) >= 3 * GROUPS) |-> (bus_rdata_o == '0));

endmodule

bind mcell_bank mcell_bank_chk #(.GROUPS(GROUPS), .GW(GW), .N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_sn      (rst_sn),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .lg_en_i     (lg_en_i),
  .lg_next_i   (lg_next_i),
  .pt_oe_i     (pt_oe_i),
  .cfg_pin_i   (cfg_pin_i),
  .cfg_oe_eq_i (cfg_oe_eq_i),
  .pin_o       (pin_o),
  .pin_oe_o    (pin_oe_o),
  .cell_q      (cell_q),
  .mask_q      (mask_q),
  .dir_q       (dir_q)
);

// File: tb/mcell_bank_test.sv
module mcell_bank_test;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [15:0] lg_en, lg_next, pt_oe, cfg_pin, cfg_oe_eq;
  logic [15:0] fb, pin, pin_oe;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    cmp_on = 1'b0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  // Behavioural model state
  bit m_cell [16];
  bit m_mask [16];
  bit m_dir  [16];

  always #5 clk = ~clk;

  mcell_bank uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .lg_en_i     (lg_en),
    .lg_next_i   (lg_next),
    .pt_oe_i     (pt_oe),
    .cfg_pin_i   (cfg_pin),
    .cfg_oe_eq_i (cfg_oe_eq),
    .fb_o        (fb),
    .pin_o       (pin),
    .pin_oe_o    (pin_oe)
  );

  // Model update at each rising edge.
  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) begin
        m_cell[i] = 0; m_mask[i] = 0; m_dir[i] = 0;
      end
    end else begin
      automatic int a = int'(bus_addr);
      automatic bit nc [16];
      for (int i = 0; i < 16; i++) begin
        if (bus_we && a == i / 8 && !m_mask[i]) nc[i] = bus_wdata[i % 8];
        else if (lg_en[i])                       nc[i] = lg_next[i];
        else                                      nc[i] = m_cell[i];
      end
      if (bus_we && (a == 2 || a == 3))
        for (int b = 0; b < 8; b++) m_mask[(a - 2) * 8 + b] = bus_wdata[b];
      if (bus_we && (a == 4 || a == 5))
        for (int b = 0; b < 8; b++) m_dir[(a - 4) * 8 + b] = bus_wdata[b];
      for (int i = 0; i < 16; i++) m_cell[i] = nc[i];
    end
  end

  function automatic logic [7:0] exp_rd();
    automatic int a = int'(bus_addr);
    automatic logic [7:0] v = '0;
    for (int b = 0; b < 8; b++) begin
      if (a < 2)      v[b] = m_cell[a * 8 + b];
      else if (a < 4) v[b] = m_mask[(a - 2) * 8 + b];
      else if (a < 6) v[b] = m_dir[(a - 4) * 8 + b];
    end
    return v;
  endfunction

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      automatic logic [15:0] e_fb, e_pin, e_oe;
      for (int i = 0; i < 16; i++) begin
        e_fb[i]  = m_cell[i];                         // R11
        e_pin[i] = cfg_pin[i] & m_cell[i];            // R10 / R11
        e_oe[i]  = cfg_pin[i] & (!cfg_oe_eq[i] | pt_oe[i] | m_dir[i]); // R8 / R9 / R10
      end
      chk(cur_req, "rdata",  {8'h00, bus_rdata}, {8'h00, exp_rd()});
      chk(cur_req, "fb",     fb,     e_fb);
      chk(cur_req, "pin",    pin,    e_pin);
      chk(cur_req, "pin_oe", pin_oe, e_oe);
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    bus_addr = a[2:0]; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string req, input int a, input logic [7:0] exp);
    bus_addr = a[2:0];
    #2;
    chk(req, $sformatf("read addr %0d", a), {8'h00, bus_rdata}, {8'h00, exp});
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      cmp_on = 1'b0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    rst_ni = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    lg_en = '0; lg_next = '0; pt_oe = '0;
    cfg_pin = 16'hFFFF; cfg_oe_eq = 16'h0000;
    repeat (2) @(posedge clk);
    #2;
    cmp_on = 1'b1;
    // R9: no enable equation, pins driven during reset
    chk("R9", "pin_oe in reset", pin_oe, 16'hFFFF);
    step();
    rst_ni = 1'b1;
    cfg_oe_eq = 16'hFFFF;
    repeat (4) step();

    cur_req = "R1";
    for (int a = 0; a < 6; a++) rd_chk("R1", a, 8'h00);

    cur_req = "R2";
    wr(0, 8'hA5); wr(1, 8'h3C);
    rd_chk("R2", 0, 8'hA5);
    rd_chk("R2", 1, 8'h3C);

    cur_req = "R4";
    wr(2, 8'h0F); wr(0, 8'hFF);
    rd_chk("R4", 0, 8'hF5);
    cur_req = "R3";
    wr(0, 8'h00);
    rd_chk("R3", 0, 8'h05);
    rd_chk("R7", 2, 8'h0F);

    // R3: masked group, bus store and logic load in the same cycle
    wr(3, 8'hFF);
    lg_en = 16'hFF00; lg_next = 16'hAA00;
    wr(1, 8'h00);
    lg_en = '0;
    rd_chk("R3", 1, 8'hAA);
    wr(1, 8'h55);
    rd_chk("R3", 1, 8'hAA);

    cur_req = "R6";
    wr(2, 8'h00);
    lg_en = 16'h00FF; lg_next = 16'h00C3;
    wr(0, 8'h3C);
    lg_en = '0;
    rd_chk("R6", 0, 8'h3C);

    cur_req = "R5";
    lg_en = 16'h00FF; lg_next = 16'h0066; step();
    lg_en = 16'h000F; lg_next = 16'h0009; step();
    lg_en = '0; step();
    rd_chk("R5", 0, 8'h69);

    cur_req = "R7";
    wr(4, 8'h5A); wr(5, 8'hA5);
    rd_chk("R7", 4, 8'h5A);
    rd_chk("R7", 5, 8'hA5);
    wr(6, 8'hFF); wr(7, 8'hFF);
    rd_chk("R7", 6, 8'h00);
    rd_chk("R7", 7, 8'h00);
    rd_chk("R7", 0, 8'h69);
    rd_chk("R7", 1, 8'hAA);
    rd_chk("R7", 2, 8'h00);
    rd_chk("R7", 3, 8'hFF);
    rd_chk("R7", 4, 8'h5A);
    rd_chk("R7", 5, 8'hA5);

    cur_req = "R8";
    pt_oe = 16'h0000; #2;
    chk("R8", "pin_oe dir only", pin_oe, 16'hA55A);
    pt_oe = 16'h0F0F; #2;
    chk("R8", "pin_oe pt|dir", pin_oe, 16'hAF5F);
    step();

    cur_req = "R9";
    pt_oe = 16'h0000; cfg_oe_eq = 16'h00FF; #2;
    chk("R9", "pin_oe no eq", pin_oe, 16'hFF5A);
    step();

    cur_req = "R10";
    cfg_pin = 16'h00FF; #2;
    chk("R10", "pin_oe node", pin_oe, 16'h005A);
    chk("R10", "pin node", pin, 16'h0069);
    chk("R11", "fb", fb, 16'hAA69);
    step();
    cfg_pin = 16'hFFFF; cfg_oe_eq = 16'hFFFF;

    // Pseudo-random run checked against the model every cycle.
    cur_req = "R2/R3/R5/R6";
    lf = 32'h1F2E3D4C;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      bus_we    = lf[0];
      bus_addr  = lf[3:1];
      bus_wdata = lf[11:4];
      lg_en     = lf[27:12];
      lg_next   = {lf[15:0]} ^ {lf[31:16]};
      pt_oe     = lf[31:16];
      cfg_pin   = lf[23:8];
      cfg_oe_eq = lf[29:14];
      step();
    end
    bus_we = 1'b0; lg_en = '0;
    repeat (3) step();
    finish_run();
  end

endmodule